// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a 32.768 kHz timebase into a periodic interrupt. The timebase arrives as a one-cycle enable pulse on the system clock. A 4-bit rate code selects the period, and a separate enable bit gates the generator. A free-running, wrapping count of timebase pulses runs inside the block. A tick fires whenever that count lands on a multiple of the selected period. Each tick sets a periodic flag and an interrupt-request flag, and the request flag drives the interrupt line.

The ticks are aligned to the free-running count, not to the moment the block was programmed. A change to the rate code or to the enable therefore realigns the next tick to the next period boundary without any extra action. A clear strobe from the surrounding status logic drops both flags.

Top module: `periodic_irq_gen`

## Requirements
- R1: While reset is asserted, and at the first edge after it, the tick pulse and both flags are 0 and the free-running count is 0.
- R2: The free-running count (CNT_W bits, default 16) advances by exactly one on each clock with `tick32_en` high and wraps from all ones to zero. A tick can occur only on a clock edge where `tick32_en` was high.
- R3: For rate codes 3 to 15, the period is 2^(code-1) timebase pulses. Code 3 gives 4 and code 15 gives 16384. A tick fires when the incremented count has its low (code-1) bits all zero.
- R4: Rate codes 1 and 2 behave as codes 8 and 9, giving periods of 128 and 256 timebase pulses.
- R5: With rate code 0, or with `per_en` low, no tick fires and both flags keep their value.
- R6: A tick gives a one-clock `tick` pulse. At the same edge it sets both `per_flag` and `req_flag`, so the two flags are always equal.
- R7: `status_clr` clears both flags at the next clock edge. When a tick falls on the same edge, the tick wins and both flags end up set.
- R8: After any change of rate code or enable, the next tick falls on the next multiple of the new period of the free-running count, not a full period after the change.
- R9: Once set, the flags stay set until a clear strobe arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick32_en | input | 1 | One-cycle pulse per 32.768 kHz timebase period |
| rate_sel | input | 4 | Rate code: 0 stops the generator; 1 and 2 are aliased to 8 and 9 |
| per_en | input | 1 | Periodic interrupt enable |
| status_clr | input | 1 | Clears both flags (status read side effect) |
| per_flag | output | 1 | Sticky periodic flag |
| req_flag | output | 1 | Sticky interrupt-request flag; drives the interrupt line |
| tick | output | 1 | One-cycle pulse at each periodic tick |

## Verification
The bench keeps the default 16-bit free-running count and the 4-bit rate code. This makes the slowest code, with a period of 16384 pulses, and a full wrap of the count at 65536 pulses reachable within the cycle budget. The bench drives the timebase enable on every clock for most phases. One phase uses gapped enables, so the count is shown to follow the enable and not the clock. Because the alignment is checked against a behavioural integer model of the count, realignment after rate and enable changes is checked directly, and so are boundary hits across the wrap and tick/clear collisions at the fast code 3.

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
  parameter int CNT_W     = 16,
  parameter int CODE_W    = 4,
  parameter int ALIAS_MAX = 2,
  parameter int ALIAS_ADD = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick32_en,
  input  logic [CODE_W-1:0] rate_sel,
  input  logic              per_en,
  input  logic              status_clr,
  output logic              per_flag,
  output logic              req_flag,
  output logic              tick
);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  mask;
  logic [CODE_W-1:0] eff_code;
  logic              running;
  logic              hit;

  assign eff_code = (rate_sel <= CODE_W'(ALIAS_MAX)) ? rate_sel + CODE_W'(ALIAS_ADD) : rate_sel;
  assign mask     = (CNT_W'(1) << (eff_code - CODE_W'(1))) - CNT_W'(1);
  assign cnt_nxt  = cnt + CNT_W'(1);
  assign running  = per_en && (rate_sel != '0);
  assign hit      = tick32_en && running && ((cnt_nxt & mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      tick     <= 1'b0;
      per_flag <= 1'b0;
      req_flag <= 1'b0;
    end else begin
      if (tick32_en) cnt <= cnt_nxt;
      tick <= hit;
      if (hit) begin
        per_flag <= 1'b1;
        req_flag <= 1'b1;
      end else if (status_clr) begin
        per_flag <= 1'b0;
        req_flag <= 1'b0;
      end
    end
  end

endmodule

module periodic_irq_gen_chk #(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick32_en,
  input logic [CODE_W-1:0] rate_sel,
  input logic              per_en,
  input logic              status_clr,
  input logic              per_flag,
  input logic              req_flag,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt
);

  a_r2_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(tick32_en));

  a_r2_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick32_en |=> $stable(cnt));

  a_r5_off_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(per_en) || $past(rate_sel) == '0) |-> !tick);

  a_r6_tick_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (per_flag && req_flag));

  a_r6_flags_equal: assert property (@(posedge clk) disable iff (!rst_n)
    per_flag == req_flag);

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_clr) && !tick) |-> (!per_flag && !req_flag));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (per_flag && !status_clr) |=> per_flag);

  a_r4_alias_code1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(rate_sel) == CODE_W'(1)) |-> (cnt[6:0] == '0));

  a_r3_code3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(rate_sel) == CODE_W'(3)) |-> (cnt[1:0] == '0));

endmodule

bind periodic_irq_gen periodic_irq_gen_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick32_en(tick32_en), .rate_sel(rate_sel),
  .per_en(per_en), .status_clr(status_clr), .per_flag(per_flag),
  .req_flag(req_flag), .tick(tick), .cnt(cnt)
);

// File: tb/sim_periodic_irq_gen.sv
module sim_periodic_irq_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick32_en = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       per_en = 1'b0;
  logic       status_clr = 1'b0;
  logic       per_flag, req_flag, tick;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  int m_cnt = 0;
  bit m_pf = 0, m_rf = 0, m_tick = 0;
  int tick_seen = 0;

  periodic_irq_gen u0 (
    .clk(clk), .rst_n(rst_n), .tick32_en(tick32_en), .rate_sel(rate_sel),
    .per_en(per_en), .status_clr(status_clr), .per_flag(per_flag),
    .req_flag(req_flag), .tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pf = 0; m_rf = 0; m_tick = 0;
    end else begin
      bit hit;
      hit = 0;
      if (tick32_en) begin
        m_cnt = (m_cnt + 1) % 65536;
        if (per_en && rate_sel != 0) begin
          int code;
          int per;
          code = (rate_sel <= 2) ? rate_sel + 7 : rate_sel;
          per = 1 << (code - 1);
          if (m_cnt % per == 0) hit = 1;
        end
      end
      m_tick = hit;
      if (hit) begin m_pf = 1; m_rf = 1; end
      else if (status_clr) begin m_pf = 0; m_rf = 0; end
    end
  end

  task automatic check1(string what, bit act, bit exp, string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at %0t: actual=%0b expected=%0b", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check1("tick", tick, m_tick, cur_req);
      check1("per_flag", per_flag, m_pf, cur_req);
      check1("req_flag", req_flag, m_rf, cur_req);
      if (tick === 1'b1) tick_seen++;
    end
  end

  task automatic run(int n, int gap, int clr_every);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      tick32_en = (gap <= 1) ? 1'b1 : (i % gap == 0);
      status_clr = (clr_every != 0) && (i % clr_every == clr_every - 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(posedge clk);
    check1("reset tick", tick, 1'b0, "R1");
    check1("reset flag", per_flag, 1'b0, "R1");
    #2 rst_n = 1'b1;

    cur_req = "R2,R6";
    rate_sel = 4'd6; per_en = 1'b1;
    run(400, 3, 0);

    cur_req = "R3,R7";
    rate_sel = 4'd3;
    run(200, 1, 7);
    run(60, 1, 4);

    cur_req = "R4";
    rate_sel = 4'd1;
    run(600, 1, 150);
    rate_sel = 4'd2;
    run(900, 1, 200);

    cur_req = "R5,R9";
    per_en = 1'b0; rate_sel = 4'd5;
    run(300, 1, 0);
    per_en = 1'b1; rate_sel = 4'd0;
    run(300, 1, 0);
    run(5, 1, 1);

    cur_req = "R8";
    rate_sel = 4'd10;
    run(300, 1, 0);
    rate_sel = 4'd4;
    run(40, 1, 0);
    per_en = 1'b0;
    run(13, 1, 0);
    per_en = 1'b1; rate_sel = 4'd7;
    run(200, 1, 50);

    cur_req = "R2,R3";
    rate_sel = 4'd15;
    run(70000, 1, 1000);

    @(negedge clk); #1;
    done = 1'b1;
    total++;
    if (tick_seen == 0) begin
      bad++;
      $display("FAIL R6 ticks observed: actual=%0d expected=nonzero", tick_seen);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule